// File: doc/BRIEF.md
# Card Fundamental-Reset Sequencer

This block owns the active-low fundamental-reset line of one add-in card slot. It watches a power-good indication from the slot supplies and a stable flag from the reference-clock source. It keeps the card in reset through power-up until three separate minimum intervals have all elapsed: power stable, reference clock stable, and a minimum time in reset. It also lets system logic pulse a warm reset, which puts the card back into reset while the supplies stay on.

All intervals are parameters in microseconds. They are turned into clock ticks from a parameterised system clock frequency, so a bench can shrink them. A loss of power pulls the reset line low in the same cycle through a combinational path. The state machine then returns to its wait-for-power state on the next edge. A one-cycle done pulse marks each release.

States: `SEQ_NOPWR` (wait for power, reset held), `SEQ_HOLD` (powered, reset held until the intervals are met), `SEQ_RUN` (reset released). The transitions are:
- NOPWR→HOLD when power-good is high.
- HOLD→RUN when all three intervals are met and no warm request is present.
- RUN→HOLD on a warm request.
- Any state→NOPWR when power-good is low.
- HOLD→HOLD with the hold timer restarted on a warm request.

Top module: `slot_rst_seq`

## Requirements
- R1: While `rst_n` is low, or while the machine waits for power, `card_rst_n` is 0 (0 means the card is in reset) and `seq_done` is 0.
- R2: `card_rst_n` rises only after `pwr_good` has been sampled high on at least PWR_STABLE_US×CLK_HZ/10^6 consecutive edges.
- R3: `card_rst_n` rises only after `refclk_stable` has been sampled high on at least CLK_STABLE_US×CLK_HZ/10^6 consecutive edges. A low sample restarts that count.
- R4: Each assertion of `card_rst_n` lasts at least MIN_ASSERT_US×CLK_HZ/10^6 cycles.
- R5: When `pwr_good` goes low, `card_rst_n` goes to 0 in the same cycle without waiting for a clock edge. The next edge puts the machine in wait-for-power.
- R6: A one-cycle `warm_req` pulse while released drives `card_rst_n` to 0 at the next edge with power kept on. The reset then holds for at least max(MIN, WARM_HOLD_US)×CLK_HZ/10^6 cycles.
- R7: A `warm_req` during a hold restarts the hold at warm length. It yields a single release and a single done pulse, with no second pulse queued.
- R8: `seq_done` is high for exactly one cycle, the first cycle in which `card_rst_n` is 1 after a hold.
- R9: A drop of `pwr_good` restarts the power-stable interval from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| pwr_good | input | 1 | Slot supplies within limits |
| refclk_stable | input | 1 | Reference clock reported stable |
| warm_req | input | 1 | Warm-reset request, one cycle per request |
| card_rst_n | output | 1 | Active-low card fundamental reset |
| seq_done | output | 1 | One-cycle pulse on release |

## Verification
The embedded assertions check on every cycle that each rising edge of the reset line was preceded by met power, clock and hold timers. They also check that a power loss sends the machine to wait-for-power, that a warm request withdraws the release, and that the done pulse never lasts two cycles. Only the bench scenarios can show the actual interval lengths against wall-clock ticks. The same goes for the restart of the clock and power counts after glitches, the merging of two warm requests into one pulse, and the same-cycle drop of the line on power failure. These are compared against a behavioural cycle model on every clock.

// File: rtl/slot_rst_pkg.sv
package slot_rst_pkg;

    typedef enum logic [1:0] {
        SEQ_NOPWR = 2'd0,
        SEQ_HOLD  = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    // Microseconds to clock ticks, rounded up, never below one tick.
    function automatic int unsigned us_to_ticks(input int unsigned hz, input int unsigned us);
        longint unsigned t;
        t = (longint'(us) * longint'(hz) + 64'd999_999) / 64'd1_000_000;
        return (t == 64'd0) ? 32'd1 : t[31:0];
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rst_ival_timer.sv
module rst_ival_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         met
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign met = (cnt_q >= limit);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import slot_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic warm_req,
    input  logic pwr_met,
    input  logic clk_met,
    input  logic hold_met,
    output logic release_q,
    output logic done_q,
    output logic warm_sel_q,
    output logic hold_clr
);
    seq_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        if (!pwr_good) begin
            state_n = SEQ_NOPWR;
        end else begin
            unique case (state_q)
                SEQ_NOPWR: state_n = SEQ_HOLD;
                SEQ_HOLD: begin
                    if (!warm_req && pwr_met && clk_met && hold_met) begin
                        state_n = SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (warm_req) begin
                        state_n = SEQ_HOLD;
                    end
                end
                default: state_n = SEQ_NOPWR;
            endcase
        end
    end

    assign hold_clr = (state_q != SEQ_HOLD) || warm_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_NOPWR;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            release_q  <= 1'b0;
            done_q     <= 1'b0;
            warm_sel_q <= 1'b0;
        end else begin
            release_q <= (state_n == SEQ_RUN);
            done_q    <= (state_q == SEQ_HOLD) && (state_n == SEQ_RUN);
            if (state_q == SEQ_NOPWR) begin
                warm_sel_q <= 1'b0;
            end else if (pwr_good && warm_req) begin
                warm_sel_q <= 1'b1;
            end
        end
    end

    // R5: a power loss always lands in wait-for-power
    a_r5_pwr_loss_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (state_q == SEQ_NOPWR));

    // R1: no release while waiting for power
    a_r1_nopwr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_NOPWR) |-> !release_q);

    // R6: a warm request while running withdraws the release
    a_r6_warm_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && warm_req) |=> !release_q);

    // R7: a warm request during a hold keeps the line held
    a_r7_warm_extends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HOLD && warm_req) |=> !release_q);

    // R8: done never lasts two cycles
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/slot_rst_seq.sv
module slot_rst_seq
    import slot_rst_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 125_000_000,
    parameter int unsigned PWR_STABLE_US = 100_000,
    parameter int unsigned CLK_STABLE_US = 100,
    parameter int unsigned MIN_ASSERT_US = 100,
    parameter int unsigned WARM_HOLD_US  = 10_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic refclk_stable,
    input  logic warm_req,
    output logic card_rst_n,
    output logic seq_done
);
    localparam int unsigned PWR_T  = us_to_ticks(CLK_HZ, PWR_STABLE_US);
    localparam int unsigned CLK_T  = us_to_ticks(CLK_HZ, CLK_STABLE_US);
    localparam int unsigned MIN_T  = us_to_ticks(CLK_HZ, MIN_ASSERT_US);
    localparam int unsigned WARM_T = umax(MIN_T, us_to_ticks(CLK_HZ, WARM_HOLD_US));
    localparam int unsigned TMAX   = umax(umax(PWR_T, CLK_T), WARM_T);
    localparam int unsigned CW     = $clog2(TMAX + 1);

    logic          pwr_met, clk_met, hold_met;
    logic          release_q, warm_sel_q, hold_clr;
    logic [CW-1:0] hold_limit;

    rst_ival_timer #(.W(CW)) u_pwr_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pwr_good),
        .limit (CW'(PWR_T)),
        .met   (pwr_met)
    );

    rst_ival_timer #(.W(CW)) u_clk_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!refclk_stable),
        .limit (CW'(CLK_T)),
        .met   (clk_met)
    );

    assign hold_limit = warm_sel_q ? CW'(WARM_T) : CW'(MIN_T);

    rst_ival_timer #(.W(CW)) u_hold_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_clr),
        .limit (hold_limit),
        .met   (hold_met)
    );

    rst_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .warm_req   (warm_req),
        .pwr_met    (pwr_met),
        .clk_met    (clk_met),
        .hold_met   (hold_met),
        .release_q  (release_q),
        .done_q     (done_q_w),
        .warm_sel_q (warm_sel_q),
        .hold_clr   (hold_clr)
    );

    logic done_q_w;

    // R5: fast path, no clock edge between power loss and reset
    assign card_rst_n = pwr_good & release_q;
    assign seq_done   = done_q_w;

    // R2: power timer satisfied before every release
    a_r2_pwr_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> $past(pwr_met));

    // R3: clock timer satisfied before every release
    a_r3_clk_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> $past(clk_met));

    // R4: hold timer satisfied before every release
    a_r4_hold_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> $past(hold_met));

endmodule

// File: tb/slot_rst_seq_bench.sv
module slot_rst_seq_bench;
    localparam int unsigned HZ = 1_000_000;
    localparam int PT = 40;
    localparam int CT = 12;
    localparam int MT = 8;
    localparam int WT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic refclk_stable = 1'b0;
    logic warm_req = 1'b0;
    logic card_rst_n;
    logic seq_done;

    always #4 clk = ~clk;

    slot_rst_seq #(
        .CLK_HZ(HZ), .PWR_STABLE_US(PT), .CLK_STABLE_US(CT),
        .MIN_ASSERT_US(MT), .WARM_HOLD_US(WT)
    ) u_slot_rst_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .refclk_stable(refclk_stable), .warm_req(warm_req),
        .card_rst_n(card_rst_n), .seq_done(seq_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // behavioural model: phase 0 waiting, 1 held, 2 released
    int m_phase = 0, m_pwr_age = 0, m_clk_age = 0, m_hold_age = 0;
    bit m_warm = 0, m_rel = 0, m_done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_pwr_age = 0; m_clk_age = 0; m_hold_age = 0;
            m_warm = 0; m_rel = 0; m_done = 0;
        end else begin
            int lim, nphase, nhold;
            bit ok, nwarm;
            lim = m_warm ? ((WT > MT) ? WT : MT) : MT;
            ok = (m_pwr_age >= PT) && (m_clk_age >= CT) && (m_hold_age >= lim);
            nphase = m_phase;
            nwarm = m_warm;
            m_done = 0;
            if (!pwr_good) nphase = 0;
            else if (m_phase == 0) nphase = 1;
            else if (m_phase == 1) begin
                if (!warm_req && ok) begin nphase = 2; m_done = 1; end
            end else if (warm_req) nphase = 1;
            if (m_phase == 0) nwarm = 0;
            else if (pwr_good && warm_req) nwarm = 1;
            nhold = (m_phase == 1 && !warm_req) ? m_hold_age + 1 : 0;
            m_pwr_age = pwr_good ? m_pwr_age + 1 : 0;
            m_clk_age = refclk_stable ? m_clk_age + 1 : 0;
            m_hold_age = nhold;
            m_phase = nphase;
            m_warm = nwarm;
            m_rel = (nphase == 2);
        end
    end

    int low_run = 0, last_low = 0, rises = 0, dones = 0;

    always @(negedge clk) begin
        bit exp_r;
        exp_r = pwr_good & m_rel;
        n_cmp++;
        if (card_rst_n !== exp_r || seq_done !== m_done) begin
            n_bad++;
            $display("FAIL %s cycle compare: card_rst_n=%b seq_done=%b expected %b %b",
                     cur_req, card_rst_n, seq_done, exp_r, m_done);
        end
        if (card_rst_n === 1'b0) low_run++;
        else if (low_run > 0) begin last_low = low_run; low_run = 0; rises++; end
        if (seq_done === 1'b1) dones++;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clr_meas();
        low_run = 0; last_low = 0; rises = 0; dones = 0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp, input bit ok);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset and no power
        cur_req = "R1";
        step(4);
        chk("R1", "card_rst_n in reset", card_rst_n, 0, card_rst_n === 1'b0);
        rst_n = 1'b1;
        step(5);
        chk("R1", "card_rst_n without power", card_rst_n, 0, card_rst_n === 1'b0);
        chk("R1", "seq_done without power", seq_done, 0, seq_done === 1'b0);

        // R2 R8: power and clock together
        cur_req = "R2";
        clr_meas();
        pwr_good = 1'b1; refclk_stable = 1'b1;
        step(60);
        chk("R2", "low cycles after power-up", last_low, PT, last_low >= PT);
        chk("R4", "minimum assertion", last_low, MT, last_low >= MT);
        chk("R8", "done pulses", dones, 1, dones == 1);
        chk("R8", "line released", card_rst_n, 1, card_rst_n === 1'b1);

        // R5: power failure, same cycle
        cur_req = "R5";
        pwr_good = 1'b0;
        #1;
        chk("R5", "combinational reset on power loss", card_rst_n, 0, card_rst_n === 1'b0);
        step(5);

        // R3: late and glitching reference clock
        cur_req = "R3";
        pwr_good = 1'b1; refclk_stable = 1'b0;
        step(50);
        chk("R3", "held without clock", card_rst_n, 0, card_rst_n === 1'b0);
        refclk_stable = 1'b1; step(6);
        refclk_stable = 1'b0; step(1);
        clr_meas();
        refclk_stable = 1'b1;
        step(30);
        chk("R3", "low cycles after clock restart", last_low, CT, last_low >= CT);
        chk("R3", "release count", rises, 1, rises == 1);

        // R6: warm reset while running
        cur_req = "R6";
        clr_meas();
        warm_req = 1'b1; step(1); warm_req = 1'b0;
        chk("R6", "reset asserted by warm", card_rst_n, 0, card_rst_n === 1'b0);
        step(40);
        chk("R6", "warm hold length", last_low, WT, last_low >= WT);
        chk("R6", "single release", rises, 1, rises == 1);

        // R7: second warm request during the hold
        cur_req = "R7";
        clr_meas();
        warm_req = 1'b1; step(1); warm_req = 1'b0;
        step(10);
        warm_req = 1'b1; step(1); warm_req = 1'b0;
        step(50);
        chk("R7", "extended hold length", last_low, 11 + WT, last_low >= 11 + WT);
        chk("R7", "one release", rises, 1, rises == 1);
        chk("R7", "one done pulse", dones, 1, dones == 1);

        // R9: power glitch during the hold restarts the power count
        cur_req = "R9";
        pwr_good = 1'b0; step(3);
        pwr_good = 1'b1; step(20);
        pwr_good = 1'b0; step(1);
        clr_meas();
        pwr_good = 1'b1;
        step(60);
        chk("R9", "low cycles after glitch", last_low, PT, last_low >= PT);
        chk("R9", "release count", rises, 1, rises == 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule